// File: doc/BRIEF.md
# System Tick Timer with Wake Deadline

This block keeps a free-running microsecond time base derived from the core clock through a parameterized prescaler. It raises a periodic system tick toward the interrupt controller. Software can ask it to swallow a given number of upcoming ticks while the processor idles without a tick. The tick schedule keeps advancing while ticks are swallowed, so the first tick raised after idle lands on the original grid.

Besides the tick, the timer holds a one-shot wake deadline. Writing a wake time can only bring this deadline earlier. When time reaches the deadline, the timer emits a hard wake pulse, and the deadline returns to the all-ones "never" value. The timer shows the earlier of the two pending deadlines as the next-event time, and it shows the low 32 bits of elapsed microseconds as a cycle counter.

Top module: `tick_wake_timer`

## Requirements
- R1: Time since reset advances by exactly one microsecond every CLK_PER_US clock cycles. `cycle_cnt` carries bits 31:0 of that count, and it reads 0 in the first cycles after reset.
- R2: After reset the tick deadline is TICK_US (default 10000). The wake deadline is all ones. `next_event` reads TICK_US, and both pulse outputs are low.
- R3: Whenever time reaches the tick deadline, the deadline moves forward by TICK_US. This happens whether or not a tick is raised.
- R4: When a tick is reached and the silent count is 0, `tick_irq` is high for exactly one clock cycle. That cycle is the first cycle in which `cycle_cnt` shows the deadline value.
- R5: When a tick is reached and the silent count is non-zero, the count drops by one and `tick_irq` stays low.
- R6: A `silent_wr` strobe loads `silent_val` into the silent count. A write of 0 lets the next tick through. A write on the same edge as a tick overrides the decrement, but the old count still decides that tick.
- R7: A `wake_wr` strobe replaces the wake deadline only when `wake_at` is strictly lower than the deadline held. A later or equal request leaves the deadline unchanged.
- R8: When time reaches or passes the wake deadline, `hard_wake` is high for one cycle, aligned with the time step. The deadline then becomes all ones, so it cannot fire again.
- R9: `next_event` always equals the smaller of the tick deadline and the wake deadline.
- R10: When both deadlines fall on the same microsecond, `tick_irq` and `hard_wake` pulse in the same cycle, and both deadlines are updated.
- R11: A wake time written at or below the current time fires on the next microsecond step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| silent_wr | input | 1 | Load strobe for the silent tick count |
| silent_val | input | SILENT_W | Number of ticks to suppress |
| wake_wr | input | 1 | Strobe for a wake-at request |
| wake_at | input | 64 | Requested wake time in microseconds |
| tick_irq | output | 1 | One-cycle system tick pulse |
| hard_wake | output | 1 | One-cycle wake pulse that overrides an interrupt lock |
| cycle_cnt | output | 32 | Low 32 bits of microseconds since reset |
| next_event | output | 64 | Earlier of the tick and wake deadlines |

## Verification
The bench swallows ticks and then checks that the first tick raised afterwards falls on the original period grid. A design that stopped the schedule during suppression would raise that tick late. The bench writes a later wake time after an earlier one; a design that did not apply min-only replacement would move the deadline out and fire late. It places a wake on a tick boundary and expects both pulses in one cycle; a design that serialized the two events would drop one pulse or delay it. It writes a wake time already in the past and expects a wake on the next step. A design that fired only on an exact match would never wake.

// File: rtl/tick_wake_timer.sv
module tick_wake_timer #(
  parameter int CLK_PER_US = 4,
  parameter int TICK_US    = 10000,
  parameter int SILENT_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                silent_wr,
  input  logic [SILENT_W-1:0] silent_val,
  input  logic                wake_wr,
  input  logic [63:0]         wake_at,
  output logic                tick_irq,
  output logic                hard_wake,
  output logic [31:0]         cycle_cnt,
  output logic [63:0]         next_event
);
  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CLK_PER_US - 1);
  localparam logic [63:0] NEVER  = '1;
  localparam logic [63:0] TICK64 = 64'(TICK_US);

  logic [PW-1:0]       pre;
  logic [63:0]         now_us, tick_dl, wake_dl, wake_keep, now_nxt;
  logic [SILENT_W-1:0] silent_cnt;
  logic                us_en, tick_hit, wake_hit;

  assign us_en     = (pre == PRE_LAST);
  assign now_nxt   = now_us + 64'd1;
  assign tick_hit  = us_en && (now_nxt >= tick_dl);
  assign wake_hit  = us_en && (now_nxt >= wake_dl);
  assign wake_keep = wake_hit ? NEVER : wake_dl;

  assign cycle_cnt  = now_us[31:0];
  assign next_event = (wake_dl < tick_dl) ? wake_dl : tick_dl;

  always_ff @(posedge clk) begin
    if (!rst_n)     pre <= '0;
    else if (us_en) pre <= '0;
    else            pre <= pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now_us     <= '0;
      tick_dl    <= TICK64;
      wake_dl    <= NEVER;
      silent_cnt <= '0;
      tick_irq   <= 1'b0;
      hard_wake  <= 1'b0;
    end else begin
      tick_irq  <= 1'b0;
      hard_wake <= 1'b0;
      if (us_en) now_us <= now_nxt;
      if (wake_hit) hard_wake <= 1'b1;
      if (tick_hit) begin
        tick_dl <= tick_dl + TICK64;
        if (silent_cnt != '0) silent_cnt <= silent_cnt - 1'b1;
        else                  tick_irq   <= 1'b1;
      end
      if (silent_wr) silent_cnt <= silent_val;
      wake_dl <= (wake_wr && (wake_at < wake_keep)) ? wake_at : wake_keep;
    end
  end
endmodule

module tick_wake_timer_chk #(
  parameter int SILENT_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick_irq,
  input logic                hard_wake,
  input logic [63:0]         now_us,
  input logic [63:0]         tick_dl,
  input logic [63:0]         wake_dl,
  input logic [SILENT_W-1:0] silent_cnt
);
  // R1
  time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (now_us != $past(now_us)) |-> (now_us == $past(now_us) + 64'd1));
  // R3
  tick_ahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_dl > now_us);
  // R4
  tick_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq |-> (now_us != $past(now_us)));
  // R5
  silent_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq |-> ($past(silent_cnt) == '0));
  // R7
  wake_only_earlier_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hard_wake && (wake_dl != $past(wake_dl))) |-> (wake_dl < $past(wake_dl)));
  // R8
  wake_to_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hard_wake |-> (now_us >= $past(wake_dl)));
endmodule

bind tick_wake_timer tick_wake_timer_chk #(.SILENT_W(SILENT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_irq(tick_irq), .hard_wake(hard_wake),
  .now_us(now_us), .tick_dl(tick_dl), .wake_dl(wake_dl), .silent_cnt(silent_cnt));

// File: tb/tick_wake_timer_tb.sv
module tick_wake_timer_tb;
  localparam int P    = 3;
  localparam int TICK = 100;
  localparam logic [63:0] NEVER = '1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        silent_wr = 1'b0;
  logic [31:0] silent_val = '0;
  logic        wake_wr = 1'b0;
  logic [63:0] wake_at = '0;
  logic        tick_irq, hard_wake;
  logic [31:0] cycle_cnt;
  logic [63:0] next_event;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tick_wake_timer #(.CLK_PER_US(P), .TICK_US(TICK), .SILENT_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .silent_wr(silent_wr), .silent_val(silent_val),
    .wake_wr(wake_wr), .wake_at(wake_at), .tick_irq(tick_irq), .hard_wake(hard_wake),
    .cycle_cnt(cycle_cnt), .next_event(next_event));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic wait_us(input int target);
    while (cycle_cnt != 32'(target)) @(negedge clk);
  endtask

  task automatic expect_event(input int target, input bit exp_tick, input bit exp_wake, input string req);
    wait_us(target);
    chk(tick_irq == exp_tick, req, 64'(tick_irq), 64'(exp_tick));
    chk(hard_wake == exp_wake, req, 64'(hard_wake), 64'(exp_wake));
    @(negedge clk);
    chk(!tick_irq && !hard_wake, {req, " pulse width"}, 64'({tick_irq, hard_wake}), 64'd0);
  endtask

  task automatic set_silent(input int n);
    silent_wr = 1'b1; silent_val = 32'(n);
    @(negedge clk);
    silent_wr = 1'b0;
  endtask

  task automatic set_wake(input logic [63:0] v);
    wake_wr = 1'b1; wake_at = v;
    @(negedge clk);
    wake_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk(cycle_cnt == 0, "R1 reset count", 64'(cycle_cnt), 64'd0);
    chk(next_event == 64'(TICK), "R2 reset next_event", next_event, 64'(TICK));
    chk(!tick_irq && !hard_wake, "R2 reset pulses", 64'({tick_irq, hard_wake}), 64'd0);
  endtask

  task automatic t_prescale;
    int n = 0;
    logic [31:0] c0;
    c0 = cycle_cnt;
    while (cycle_cnt == c0) @(negedge clk);
    c0 = cycle_cnt;
    while (cycle_cnt == c0) begin @(negedge clk); n++; end
    chk(n == P, "R1 cycles per us", 64'(n), 64'(P));
    chk(cycle_cnt == c0 + 1, "R1 step size", 64'(cycle_cnt), 64'(c0 + 1));
  endtask

  task automatic t_tick;
    expect_event(100, 1'b1, 1'b0, "R4 first tick");
    chk(next_event == 200, "R3 deadline advanced", next_event, 64'd200);
    expect_event(200, 1'b1, 1'b0, "R4 second tick");
  endtask

  task automatic t_silent;
    wait_us(210);
    set_silent(2);
    expect_event(300, 1'b0, 1'b0, "R5 suppressed 1");
    chk(next_event == 400, "R3 schedule kept while silent", next_event, 64'd400);
    expect_event(400, 1'b0, 1'b0, "R5 suppressed 2");
    expect_event(500, 1'b1, 1'b0, "R5 tick back on grid");
  endtask

  task automatic t_cancel;
    wait_us(510);
    set_silent(3);
    set_silent(0);
    expect_event(600, 1'b1, 1'b0, "R6 zero write ends suppression");
  endtask

  task automatic t_wake;
    wait_us(610);
    set_wake(64'd647);
    chk(next_event == 647, "R9 wake earlier than tick", next_event, 64'd647);
    set_wake(64'd680);
    chk(next_event == 647, "R7 later wake ignored", next_event, 64'd647);
    expect_event(647, 1'b0, 1'b1, "R8 wake fires");
    chk(next_event == 700, "R8 wake back to never", next_event, 64'd700);
    expect_event(680, 1'b0, 1'b0, "R7 ignored request never fires");
  endtask

  task automatic t_coincide;
    wait_us(690);
    set_wake(64'd800);
    chk(next_event == 700, "R9 tick earlier than wake", next_event, 64'd700);
    expect_event(700, 1'b1, 1'b0, "R10 tick before shared");
    chk(next_event == 800, "R9 next is shared deadline", next_event, 64'd800);
    expect_event(800, 1'b1, 1'b1, "R10 both in one cycle");
    chk(next_event == 900, "R10 both deadlines updated", next_event, 64'd900);
  endtask

  task automatic t_past;
    int n = 0;
    logic [31:0] c0;
    wait_us(820);
    c0 = cycle_cnt;
    set_wake(64'd805);
    while (!hard_wake && n < 2 * P) begin
      if (cycle_cnt != c0) break;
      @(negedge clk); n++;
    end
    chk(hard_wake == 1'b1, "R11 past wake fires", 64'(hard_wake), 64'd1);
    chk(cycle_cnt == c0 + 1, "R11 on next step", 64'(cycle_cnt), 64'(c0 + 1));
    @(negedge clk);
    chk(next_event == 900, "R11 deadline cleared", next_event, 64'd900);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prescale();
    t_tick();
    t_silent();
    t_cancel();
    t_wake();
    t_coincide();
    t_past();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule